// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block turns one external interrupt request pin into a latched status flag and a gated interrupt request for a processor. The raw pin first passes through a synchronizer chain. It is then compared against a software-selected active polarity. A move from the inactive to the active level sets the flag.

Two detection modes are available. In edge mode, the flag stays set until software acknowledges it. In edge-plus-level mode, the flag is also forced on for as long as the pin sits at its active level, so an acknowledge only takes effect after the pin has been released.

The block also reports the synchronized pin level, so software can poll the pin. It drives two digital controls for the pad's internal pull device: an enable, and a direction that selects a pull toward the inactive level.

Top module: `ext_irq_detect`

## Requirements
- R1: `pin_level_o` equals the value `pin_i` had at the rising clock edge two edges earlier (two-flop synchronizer), and it is 0 out of reset.
- R2: With `pol_high_i`=1 the active level of the pin is 1. With `pol_high_i`=0 it is 0.
- R3: A synchronized move from the inactive to the active level sets `flag_o`. The flag is visible after the third rising edge that follows the pin change.
- R4: In edge mode (`level_mode_i`=0), an `ack_i` high at a rising edge clears `flag_o` at that edge. If a new edge is detected in the same cycle, the flag stays set.
- R5: In edge-plus-level mode (`level_mode_i`=1), `flag_o` is set at every edge while the synchronized pin is active, and `ack_i` has no effect then. Once the pin is inactive, `ack_i` clears it.
- R6: `irq_o` is high exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R7: `pull_en_o` is 1 when `enable_i`=1 and `pull_off_i`=0, and 0 otherwise. `pull_dn_o`=1 selects a pull-down and is driven only with `pol_high_i`=1 and `pull_en_o`=1. A pull-up is signalled by `pull_en_o`=1 with `pull_dn_o`=0.
- R8: While `enable_i`=0, `flag_o` is cleared at the next rising edge, `irq_o` stays low and both pull controls are 0.
- R9: Without an acknowledge, a set flag holds through pin deassertion while the block is enabled.
- R10: In edge mode a pin that remains at its active level after an acknowledge does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw external interrupt pin |
| enable_i | input | 1 | Pin function enable |
| pol_high_i | input | 1 | 1: rising/high active, 0: falling/low active |
| level_mode_i | input | 1 | 0: edge only, 1: edge plus level |
| pull_off_i | input | 1 | 1 disables the internal pull device |
| ack_i | input | 1 | Flag acknowledge strobe |
| irq_en_i | input | 1 | Local interrupt enable |
| flag_o | output | 1 | Interrupt status flag |
| irq_o | output | 1 | Interrupt request to processor |
| pin_level_o | output | 1 | Synchronized raw pin level |
| pull_en_o | output | 1 | Pull device enable |
| pull_dn_o | output | 1 | Pull direction, 1 = pull-down |

## Verification
The assertions assume that `rst_ni` is released only with `enable_i` low. They also assume that the control inputs are steady at each rising edge, since they are consumed unsynchronized. The bench therefore changes every input, including the asynchronous pin, only on falling edges. It holds the block disabled through reset.

The bench fixes the polarity before the pin moves in the directed phases. The random phase may flip the polarity at any time, and its reference model treats the resulting level change as a real edge.

// File: rtl/eid_pkg.sv
package eid_pkg;
  typedef enum logic {
    MODE_EDGE       = 1'b0,
    MODE_EDGE_LEVEL = 1'b1
  } det_mode_e;

  typedef struct packed {
    logic en;
    logic dn;
  } pull_ctl_t;
endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES:0] chain;
  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g+1] <= RST_VAL;
      else         chain[g+1] <= chain[g];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/eid_detect.sv
module eid_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic pol_high_i,
  output logic active_o,
  output logic edge_o
);
  logic prev_q;

  assign active_o = pol_high_i ? level_i : ~level_i;

  // prev resets as active so no edge is seen straight out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= active_o;
  end

  assign edge_o = active_o & ~prev_q;
endmodule

// File: rtl/eid_flag.sv
module eid_flag
  import eid_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enable_i,
  input  det_mode_e mode_i,
  input  logic      active_i,
  input  logic      edge_i,
  input  logic      ack_i,
  output logic      flag_o
);
  logic flag_q, flag_d, lvl_hold;

  assign lvl_hold = (mode_i == MODE_EDGE_LEVEL) & active_i;

  // set wins over acknowledge
  always_comb begin
    flag_d = 1'b0;
    if (enable_i) flag_d = edge_i | lvl_hold | (flag_q & ~ack_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/eid_pull.sv
module eid_pull
  import eid_pkg::*;
(
  input  logic      enable_i,
  input  logic      pull_off_i,
  input  logic      pol_high_i,
  output pull_ctl_t ctl_o
);
  always_comb begin
    ctl_o.en = enable_i & ~pull_off_i;
    ctl_o.dn = ctl_o.en & pol_high_i;
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import eid_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic enable_i,
  input  logic pol_high_i,
  input  logic level_mode_i,
  input  logic pull_off_i,
  input  logic ack_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o,
  output logic pin_level_o,
  output logic pull_en_o,
  output logic pull_dn_o
);
  logic      pin_sync, pin_active, pin_edge, flag;
  pull_ctl_t pull_ctl;
  det_mode_e mode;

  assign mode = det_mode_e'(level_mode_i);

  eid_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  eid_detect u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (pin_sync),
    .pol_high_i(pol_high_i),
    .active_o  (pin_active),
    .edge_o    (pin_edge)
  );

  eid_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .mode_i  (mode),
    .active_i(pin_active),
    .edge_i  (pin_edge),
    .ack_i   (ack_i),
    .flag_o  (flag)
  );

  eid_pull u_pull (
    .enable_i  (enable_i),
    .pull_off_i(pull_off_i),
    .pol_high_i(pol_high_i),
    .ctl_o     (pull_ctl)
  );

  assign flag_o      = flag;
  assign irq_o       = flag & irq_en_i;
  assign pin_level_o = pin_sync;
  assign pull_en_o   = pull_ctl.en;
  assign pull_dn_o   = pull_ctl.dn;
endmodule

// File: rtl/eid_checker.sv
module eid_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_i,
  input logic enable_i,
  input logic pol_high_i,
  input logic level_mode_i,
  input logic pull_off_i,
  input logic ack_i,
  input logic irq_en_i,
  input logic flag_o,
  input logic irq_o,
  input logic pin_level_o,
  input logic pull_en_o,
  input logic pull_dn_o
);
  logic [1:0] seen_q;
  logic       act_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             seen_q <= 2'd0;
    else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
  end

  assign act_c = pol_high_i ? pin_level_o : ~pin_level_o;

  assert_sync_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == 2'd2) |-> (pin_level_o == $past(pin_i, 2)));

  assert_level_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && level_mode_i && act_c) |=> flag_o);

  assert_irq_needs_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i));

  assert_irq_raised_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && irq_en_i) |-> irq_o);

  assert_pull_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !pull_off_i) |-> pull_en_o);

  assert_pull_cut_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_off_i |-> !pull_en_o);

  assert_pull_dir_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_dn_o |-> (pol_high_i && pull_en_o));

  assert_flag_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !flag_o);

  assert_pull_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (!pull_en_o && !pull_dn_o));

  assert_flag_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && flag_o && !ack_i) |=> flag_o);
endmodule

bind ext_irq_detect eid_checker u_chk (.*);

// File: tb/tb_ext_irq_detect.sv
module tb_ext_irq_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, en = 1'b0, pol = 1'b0, lvl = 1'b0, poff = 1'b0, ack = 1'b0, ien = 1'b0;
  logic flag, irq, plev, pen, pdn;

  // staged stimulus, applied on the falling edge
  logic s_pin = 1'b0, s_en = 1'b0, s_pol = 1'b0, s_lvl = 1'b0, s_poff = 1'b0, s_ack = 1'b0, s_ien = 1'b0;

  // reference state
  logic m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b1, m_flag = 1'b0;

  typedef struct {
    string tag;
    logic  flag, irq, lev, pen, pdn;
  } exp_t;
  exp_t sb_q[$];

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .enable_i(en), .pol_high_i(pol),
    .level_mode_i(lvl), .pull_off_i(poff), .ack_i(ack), .irq_en_i(ien),
    .flag_o(flag), .irq_o(irq), .pin_level_o(plev), .pull_en_o(pen), .pull_dn_o(pdn)
  );

  task automatic check(input string tag, input string field, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, field, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input int n = 1);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      logic act_old, edg;
      @(negedge clk);
      pin = s_pin; en = s_en; pol = s_pol; lvl = s_lvl; poff = s_poff; ack = s_ack; ien = s_ien;
      #1;
      e.tag  = tag;
      e.flag = m_flag;
      e.irq  = m_flag & ien;
      e.lev  = m_s2;
      e.pen  = en & ~poff;
      e.pdn  = en & ~poff & pol;
      sb_q.push_back(e);
      @(posedge clk);
      act_old = pol ? m_s2 : ~m_s2;
      edg     = act_old & ~m_prev;
      m_flag  = en & (edg | (lvl & act_old) | (m_flag & ~ack));
      m_prev  = act_old;
      m_s2    = m_s1;
      m_s1    = pin;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, "flag_o", flag, e.flag);
        check(e.tag, "irq_o", irq, e.irq);
        check(e.tag, "pin_level_o", plev, e.lev);
        check(e.tag, "pull_en_o", pen, e.pen);
        check(e.tag, "pull_dn_o", pdn, e.pdn);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #3;
    check("R1 reset", "pin_level_o", plev, 1'b0);
    check("R8 reset", "flag_o", flag, 1'b0);
    check("R8 reset", "irq_o", irq, 1'b0);
    check("R8 reset", "pull_en_o", pen, 1'b0);
    #20;
    rst_n = 1'b1;
    s_pin = 1'b1;
    cyc("R8 disabled idle", 3);

    // low-active, edge mode
    s_en = 1; s_pol = 0; s_ien = 1;
    cyc("R7 pull-up", 4);
    s_pin = 0;
    cyc("R3 falling edge", 5);
    s_ack = 1; cyc("R4 ack clears"); s_ack = 0;
    cyc("R10 level ignored in edge mode", 4);
    s_pin = 1; cyc("R9 release", 3);
    s_pin = 0; cyc("R3 second edge", 4);
    s_pin = 1; cyc("R9 flag holds", 5);
    s_ack = 1; cyc("R4 ack"); s_ack = 0;
    cyc("R4 cleared", 2);

    // ack coincident with new edge
    s_pin = 0; cyc("R4 edge pending", 2);
    s_ack = 1; cyc("R4 ack with edge"); s_ack = 0;
    cyc("R4 edge wins", 2);
    s_ien = 0; cyc("R6 irq masked", 2);
    s_ien = 1; cyc("R6 irq unmasked", 2);
    s_ack = 1; cyc("R4 ack"); s_ack = 0;
    s_pin = 1; cyc("R10 settle", 3);

    // high-active
    s_en = 0; cyc("R8 disable", 2);
    s_pin = 0; s_pol = 1; cyc("R2 setup", 3);
    s_en = 1; cyc("R7 pull-down", 3);
    s_poff = 1; cyc("R7 pull off", 2);
    s_pin = 1; cyc("R2 rising edge", 5);
    s_poff = 0;
    s_ack = 1; cyc("R4 ack high pol"); s_ack = 0;
    s_pin = 0; cyc("R2 release", 3);

    // edge plus level
    s_lvl = 1;
    s_pin = 1; cyc("R5 assert", 4);
    s_ack = 1; cyc("R5 ack ignored", 3); s_ack = 0;
    cyc("R5 held", 2);
    s_pin = 0; cyc("R5 release", 3);
    cyc("R9 holds after release", 2);
    s_ack = 1; cyc("R5 ack clears"); s_ack = 0;
    cyc("R5 cleared", 2);

    // disable while set
    s_pin = 1; cyc("R5 set again", 4);
    s_en = 0; cyc("R8 flag cleared", 3);
    s_en = 1; cyc("R5 enable on asserted pin", 3);
    s_en = 0; s_pin = 0; cyc("R8 off", 3);

    // random mix
    s_en = 1;
    for (int k = 0; k < 300; k++) begin
      int unsigned r;
      r = $urandom;
      s_pin  = r[0];
      s_ack  = r[3:1] == 3'd0;
      s_ien  = r[4] | r[5];
      s_poff = r[9:6] == 4'd0;
      s_lvl  = (r[15:10] == 6'd0) ? ~s_lvl : s_lvl;
      s_pol  = (r[21:16] == 6'd0) ? ~s_pol : s_pol;
      s_en   = (r[27:22] == 6'd0) ? ~s_en : s_en;
      cyc("R1 R3 R4 R5 R6 random");
    end

    @(negedge clk);
    #5;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule